// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This controller gathers level-sensitive interrupt requests from on-chip peripherals and drives a single interrupt line toward a host processor. Software works with it through a small register port. A mask register enables sources one at a time. A pending register shows the raw request lines. An in-service register records the sources whose handlers are still running. A configuration register holds a master enable, a favoured-source field and the request level shown to the host.

To take an interrupt, the host writes a 1 to bit 0 of the vector register and then reads that register. The write latches the winning source number and marks that source in service in the same clock. The read returns the number in bits 15:11. When the handler finishes, the host clears the source's in-service bit by writing a 1 to that bit. Vector 0 is reserved as the error vector. It is returned when no source is eligible at the moment of the acknowledge write, which happens when a request was masked or withdrawn after the line to the host was raised. Source slot 0 is therefore never a real source.

Top module: `vec_intc`

## Requirements
- R1: After reset, the configuration, mask and in-service registers read 0, the vector register reads 0 and `irq_o` is low.
- R2: A source is eligible when its request is high, its mask bit is 1 and its in-service bit is 0. While the master enable is set, `irq_o` is the OR of all eligible sources.
- R3: While the master enable (configuration bit 7) is 0, `irq_o` stays low whatever the requests are.
- R4: A write to the vector register (address 4) with bit 0 set is an acknowledge. A later read of address 4 returns the latched vector in bits 15:11 with all other bits 0. A write to address 4 with bit 0 clear changes neither the vector nor the in-service register.
- R5: Without an active favoured source, the acknowledge grants the eligible source with the highest number.
- R6: If the favoured-source field (configuration bits 12:8) is nonzero and names an eligible source, that source wins. If it names a source that is not eligible, the order of R5 applies.
- R7: The acknowledge sets the granted source's in-service bit in the same clock that it latches the vector, so that source is no longer eligible for the next acknowledge.
- R8: A write to the in-service register (address 3) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: If no source is eligible at the acknowledge write, the vector latches the error value 0 and the in-service register does not change.
- R10: Configuration bits 15:13 appear on `irq_level_o`, and the configuration register (address 0) reads back bits 15:7 as written, with all other bits 0.
- R11: The pending register (address 1) returns the request lines. Bit 0 reads 0 in the pending, mask (address 2) and in-service registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt line to the host |
| irq_level_o | output | 3 | Request level presented to the host |

## Verification
The case that matters is a request line dropping in the same clock in which the acknowledge write reaches the register. The raised host line and the vector latch then disagree, and the controller must return the error vector instead of a stale source number. The bench provokes this by driving the request low and the acknowledge write in the same half-cycle, after it has checked that `irq_o` is high. It then expects vector 0 and an unchanged in-service register. The same collision is also produced by clearing the mask just before the acknowledge.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

    localparam int VEC_W  = 5;
    localparam int ADDR_W = 3;
    localparam logic [VEC_W-1:0] ERR_VEC = '0;

    typedef enum logic [ADDR_W-1:0] {
        RA_CFG   = 3'd0,
        RA_PEND  = 3'd1,
        RA_MASK  = 3'd2,
        RA_INSVC = 3'd3,
        RA_VEC   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [2:0]       level;
        logic [VEC_W-1:0] favor;
        logic             enable;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [31:0] w);
        cfg_t c;
        c.level  = w[15:13];
        c.favor  = w[12:8];
        c.enable = w[7];
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input cfg_t c);
        return {16'b0, c.level, c.favor, c.enable, 7'b0};
    endfunction

    function automatic logic [31:0] vec_pack(input logic [VEC_W-1:0] v);
        return {16'b0, v, 11'b0};
    endfunction

endpackage

// File: rtl/vec_intc_resolve.sv
module vec_intc_resolve
    import vec_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0]  elig,
    input  logic [VEC_W-1:0] favor,
    output logic [VEC_W-1:0] win,
    output logic             any
);

    logic [NSRC-1:0]  above;
    logic [NSRC-1:0]  pick;
    logic [VEC_W-1:0] top_idx;
    logic             fav_ok;

    assign above[NSRC-1] = 1'b0;
    for (genvar i = 0; i < NSRC - 1; i++) begin : g_chain
        assign above[i] = above[i+1] | elig[i+1];
    end

    assign pick = elig & ~above;

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pick[i]) top_idx = top_idx | VEC_W'(i);
        end
    end

    assign fav_ok = (favor != '0) && |((NSRC'(1) << favor) & elig);
    assign any    = |elig;
    assign win    = fav_ok ? favor : top_idx;

endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
    import vec_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [NSRC-1:0]   src,
    input  logic [VEC_W-1:0]  win,
    input  logic              any,
    output cfg_t              cfg_q,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   insvc_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [31:0]       rdata
);

    localparam logic [NSRC-1:0] KEEP = {{(NSRC-1){1'b1}}, 1'b0};

    logic ack;
    assign ack = we && (addr == RA_VEC) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            mask_q  <= '0;
            insvc_q <= '0;
            vec_q   <= ERR_VEC;
        end else begin
            if (we && addr == RA_CFG)  cfg_q  <= cfg_unpack(wdata);
            if (we && addr == RA_MASK) mask_q <= wdata[NSRC-1:0] & KEEP;
            if (ack) begin
                vec_q <= any ? win : ERR_VEC;
                if (any) insvc_q <= insvc_q | (NSRC'(1) << win);
            end else if (we && addr == RA_INSVC) begin
                insvc_q <= insvc_q & ~wdata[NSRC-1:0];
            end
        end
    end

    always_comb begin
        case (addr)
            RA_CFG:   rdata = cfg_pack(cfg_q);
            RA_PEND:  rdata = 32'(src & KEEP);
            RA_MASK:  rdata = 32'(mask_q);
            RA_INSVC: rdata = 32'(insvc_q);
            RA_VEC:   rdata = vec_pack(vec_q);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/vec_intc.sv
module vec_intc
    import vec_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o,
    output logic [2:0]        irq_level_o
);

    localparam logic [NSRC-1:0] SLOT_KEEP = {{(NSRC-1){1'b1}}, 1'b0};

    cfg_t             cfg_q;
    logic [NSRC-1:0]  mask_q;
    logic [NSRC-1:0]  insvc_q;
    logic [VEC_W-1:0] vec_q;
    logic [NSRC-1:0]  elig;
    logic [VEC_W-1:0] win;
    logic             any;

    assign elig = src_i & mask_q & ~insvc_q & SLOT_KEEP;

    vec_intc_resolve #(.NSRC(NSRC)) u_resolve (
        .elig  (elig),
        .favor (cfg_q.favor),
        .win   (win),
        .any   (any)
    );

    vec_intc_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .src     (src_i),
        .win     (win),
        .any     (any),
        .cfg_q   (cfg_q),
        .mask_q  (mask_q),
        .insvc_q (insvc_q),
        .vec_q   (vec_q),
        .rdata   (reg_rdata)
    );

    assign irq_o       = cfg_q.enable & any;
    assign irq_level_o = cfg_q.level;

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
    import vec_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_i,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              irq_o,
    input logic              cfg_en,
    input logic [NSRC-1:0]   mask_q,
    input logic [NSRC-1:0]   insvc_q,
    input logic [VEC_W-1:0]  vec_q,
    input logic [VEC_W-1:0]  win,
    input logic              any
);

    logic [NSRC-1:0] win_mask;
    logic [NSRC-1:0] live;
    logic            ack_w;
    logic            clr_w;

    assign win_mask = NSRC'(1) << win;
    assign live     = src_i & mask_q & ~insvc_q;
    assign ack_w    = reg_we && (reg_addr == RA_VEC) && reg_wdata[0];
    assign clr_w    = reg_we && (reg_addr == RA_INSVC);

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> cfg_en);

    // R2
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (|live));

    // R5
    win_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> (|(win_mask & live)));

    // R7
    ack_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_w && any) |=> ((|(insvc_q & $past(win_mask))) && vec_q == $past(win)));

    // R9
    ack_err_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_w && !any) |=> (vec_q == ERR_VEC && $stable(insvc_q)));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_w |=> ((insvc_q & $past(reg_wdata[NSRC-1:0])) == '0));

endmodule

bind vec_intc vec_intc_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_o     (irq_o),
    .cfg_en    (cfg_q.enable),
    .mask_q    (mask_q),
    .insvc_q   (insvc_q),
    .vec_q     (vec_q),
    .win       (win),
    .any       (any)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;

    localparam int N = 8;
    localparam logic [2:0] A_CFG = 3'd0, A_PEND = 3'd1, A_MASK = 3'd2,
                           A_INSVC = 3'd3, A_VEC = 3'd4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_i = '0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_o;
    logic [2:0]   irq_level_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    vec_intc #(.NSRC(N)) u_vec_intc (
        .clk(clk), .rst(rst), .src_i(src_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_level_o(irq_level_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [4:0] model_win(input logic [N-1:0] e, input logic [4:0] fav);
        logic [4:0] r = 5'd0;
        if (fav != 0 && fav < N && e[fav[2:0]]) return fav;
        for (int i = 1; i < N; i++) if (e[i]) r = 5'(i);
        return r;
    endfunction

    initial begin
        logic [31:0] d;
        logic [N-1:0] m;
        logic [N-1:0] e;
        logic [4:0]   w;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CFG, d);   check("R1 cfg", d, 0);
        rd(A_MASK, d);  check("R1 mask", d, 0);
        rd(A_INSVC, d); check("R1 insvc", d, 0);
        rd(A_VEC, d);   check("R1 vec", d, 0);
        check("R1 irq", {31'b0, irq_o}, 0);

        // R11 pending mirrors requests, bit 0 reads zero
        src_i = 8'h3D;
        rd(A_PEND, d);  check("R11 pend", d, 32'h3C);
        wr(A_MASK, 32'hFF);
        rd(A_MASK, d);  check("R11 mask bit0", d, 32'hFE);

        // R3 master enable gates the line
        src_i = 8'h10;
        #1 check("R3 irq off", {31'b0, irq_o}, 0);
        wr(A_CFG, 32'h80);
        #1 check("R3 irq on", {31'b0, irq_o}, 1);

        // R10 level field and readback
        wr(A_CFG, 32'hFFFF_A0FF);
        #1 check("R10 level", {29'b0, irq_level_o}, 5);
        rd(A_CFG, d);   check("R10 cfg readback", d, 32'h0000_A080);
        wr(A_CFG, 32'h80);

        // R2/R4/R5/R7/R9 sweep over masks and all request patterns
        for (int mi = 0; mi < 4; mi++) begin
            case (mi)
                0: m = 8'hFE;
                1: m = 8'hAA;
                2: m = 8'h5F;
                default: m = 8'h00;
            endcase
            for (int p = 0; p < 256; p++) begin
                wr(A_MASK, 32'(m));
                src_i = N'(p);
                e = N'(p) & m & 8'hFE;
                w = model_win(e, 5'd0);
                #1 check("R2 irq", {31'b0, irq_o}, {31'b0, |e});
                wr(A_VEC, 32'h1);
                rd(A_VEC, d);   check("R5 vec", d, {16'b0, w, 11'b0});
                rd(A_INSVC, d); check("R7 insvc", d, (w == 0) ? 32'h0 : (32'h1 << w));
                wr(A_INSVC, 32'hFF);
            end
        end

        // R6 favoured source, then R7 successive grants
        wr(A_CFG, 32'h0280);
        wr(A_MASK, 32'hFF);
        src_i = 8'h46;
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R6 favour", d, {16'b0, 5'd2, 11'b0});
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R7 next", d, {16'b0, 5'd6, 11'b0});
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R7 third", d, {16'b0, 5'd1, 11'b0});
        #1 check("R7 irq drop", {31'b0, irq_o}, 0);
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R9 none left", d, 0);
        rd(A_INSVC, d);   check("R9 insvc kept", d, 32'h46);

        // R8 write-one-to-clear
        wr(A_INSVC, 32'h0);   rd(A_INSVC, d); check("R8 zero write", d, 32'h46);
        wr(A_INSVC, 32'h04);  rd(A_INSVC, d); check("R8 clear one", d, 32'h42);

        // R4 write with bit0 clear is ignored
        wr(A_VEC, 32'hFFFE);
        rd(A_VEC, d);   check("R4 no ack vec", d, 0);
        rd(A_INSVC, d); check("R4 no ack insvc", d, 32'h42);
        wr(A_INSVC, 32'hFF);

        // R6 favoured source not eligible falls back
        wr(A_CFG, 32'h0380);
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R6 fallback", d, {16'b0, 5'd6, 11'b0});
        wr(A_INSVC, 32'hFF);
        wr(A_CFG, 32'h80);

        // R9 race: request withdrawn in the acknowledge cycle
        src_i = 8'h20;
        #1 check("R9 irq before race", {31'b0, irq_o}, 1);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = A_VEC; reg_wdata = 32'h1; src_i = 8'h00;
        @(negedge clk);
        reg_we = 1'b0;
        rd(A_VEC, d);   check("R9 race vec", d, 0);
        rd(A_INSVC, d); check("R9 race insvc", d, 0);

        // R9 race: masked before acknowledge
        src_i = 8'h20;
        wr(A_MASK, 32'h0);
        wr(A_VEC, 32'h1); rd(A_VEC, d); check("R9 masked vec", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule